// File: doc/BRIEF.md
# RTS Flow-Control Delay Generator

This block drives the active-low request-to-send line of a serial receiver. When a character has been fully received, the line goes high (not ready). It stays high for a programmable number of bit periods and then falls low again. The time base is a one-cycle bit-rate tick. The receiver reports events to the block: a pulse when a character completes, and a pulse when a new frame is seen. If a new frame is seen before the delay has expired, the line stays high until the next character completes and a fresh delay has run out.

A small configuration register holds a delay-select field and an enable bit. While the block is disabled, the pin simply carries a general-purpose output value. A receive-init pulse clears this configuration and any delay in progress, so software must program the register again afterwards.

Top module: `rts_delay_gen`

## Requirements
- R1: After reset the enable bit and the select field are 0, so `rts_n` equals `gpo_val`.
- R2: While the enable bit is 0, `rts_n` equals `gpo_val` in every cycle, whatever the receiver events are.
- R3: While enabled and `rx_en` is 0, `rts_n` is 1.
- R4: While enabled, with `rx_en` at 1 and no delay pending, `rts_n` is 0.
- R5: A write with `cfg_we` loads `cfg_wdata[1:0]` into the select field and `cfg_wdata[2]` into the enable bit. Select codes 0, 1, 2 and 3 give delays of 0, 1, 2 and 4 bit periods. After a `char_done` pulse with a nonzero delay, `rts_n` is 1 from the following cycle. It falls to 0 in the cycle after the edge on which the delay's last `bit_tick` is taken.
- R6: With select code 0, `rts_n` is 0 in the cycle after `char_done`.
- R7: The delay counts down only on cycles where `bit_tick` is 1. Without ticks, `rts_n` stays 1.
- R8: A `char_done` pulse during a pending delay reloads the full delay.
- R9: A `frame_start` pulse during a pending delay keeps `rts_n` at 1 regardless of ticks, until the next `char_done` starts a fresh delay. A `frame_start` pulse with no delay pending has no effect.
- R10: `rx_init` clears the enable bit, the select field and any pending delay, and it takes priority over a simultaneous `cfg_we`. In the following cycle `rts_n` equals `gpo_val`.
- R11: When `char_done` and `bit_tick` occur in the same cycle, the reload wins and no tick is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_init | input | 1 | Receive-init pulse that clears the configuration and the delay |
| rx_en | input | 1 | Receiver enabled |
| char_done | input | 1 | Pulse when a character has been completely received |
| frame_start | input | 1 | Pulse when a new frame is detected |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | [1:0] delay select, [2] enable |
| gpo_val | input | 1 | General-purpose output value used while disabled |
| rts_n | output | 1 | Request to send, active low |

## Verification
Each of the four select codes is run with a train of ticks that has tick-free gaps inserted. This separates the exact delay length from any counting on plain clock cycles. A restarted character, a frame seen in mid-delay, and a character that coincides with a tick each produce their own rts_n waveform, which tells reload, hold and priority apart. Toggling the general-purpose value while disabled, and pulsing receive-init alongside a configuration write, separate the pin-ownership and clearing paths from the flow-control path.

// File: rtl/rts_delay_gen.sv
module rts_delay_gen #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_init,
  input  logic             rx_en,
  input  logic             char_done,
  input  logic             frame_start,
  input  logic             bit_tick,
  input  logic             cfg_we,
  input  logic [SEL_W:0]   cfg_wdata,
  input  logic             gpo_val,
  output logic             rts_n
);

  localparam int MAX_DLY = 1 << ((1 << SEL_W) - 2);
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic [SEL_W-1:0] sel;
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic             hold;
  logic [CNT_W-1:0] load;
  logic             pending;

  assign load    = (sel == '0) ? '0 : ({{(CNT_W-1){1'b0}}, 1'b1} << (sel - 1'b1));
  assign pending = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      en   <= 1'b0;
      cnt  <= '0;
      hold <= 1'b0;
    end else if (rx_init) begin
      sel  <= '0;
      en   <= 1'b0;
      cnt  <= '0;
      hold <= 1'b0;
    end else begin
      if (cfg_we) begin
        sel <= cfg_wdata[SEL_W-1:0];
        en  <= cfg_wdata[SEL_W];
      end
      if (!rx_en) begin
        cnt  <= '0;
        hold <= 1'b0;
      end else if (char_done) begin
        cnt  <= load;
        hold <= 1'b0;
      end else begin
        if (bit_tick && pending) cnt <= cnt - 1'b1;
        if (frame_start && pending) hold <= 1'b1;
      end
    end
  end

  assign rts_n = en ? (!rx_en || hold || pending) : gpo_val;

endmodule

// File: rtl/rts_delay_chk.sv
module rts_delay_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_init,
  input logic             rx_en,
  input logic             char_done,
  input logic             frame_start,
  input logic             bit_tick,
  input logic             cfg_we,
  input logic             gpo_val,
  input logic             rts_n,
  input logic             en,
  input logic [SEL_W-1:0] sel
);

  logic quiet;
  assign quiet = !rx_init && !cfg_we;

  p_init_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_init |=> (rts_n == gpo_val));

  p_zero_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && en && rx_en && sel == '0 && quiet) |=> (!rts_n || !rx_en));

  p_delay_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && en && rx_en && sel != '0 && quiet) |=> rts_n);

  p_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && rts_n && en && rx_en && !char_done && quiet) |=> rts_n);

  p_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_n && en && rx_en && !bit_tick && !char_done && quiet) |=> rts_n);

  p_reload_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && bit_tick && en && rx_en && sel != '0 && quiet) |=> rts_n);

endmodule

bind rts_delay_gen rts_delay_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_init(rx_init), .rx_en(rx_en),
  .char_done(char_done), .frame_start(frame_start), .bit_tick(bit_tick),
  .cfg_we(cfg_we), .gpo_val(gpo_val), .rts_n(rts_n), .en(en), .sel(sel)
);

// File: tb/sim_rts_delay_gen.sv
`timescale 1ns/1ps
module sim_rts_delay_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_init = 0, rx_en = 0, char_done = 0, frame_start = 0, bit_tick = 0, cfg_we = 0, gpo_val = 0;
  logic [2:0] cfg_wdata = '0;
  logic rts_n;
  int runs = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rts_delay_gen u0 (
    .clk(clk), .rst_n(rst_n), .rx_init(rx_init), .rx_en(rx_en),
    .char_done(char_done), .frame_start(frame_start), .bit_tick(bit_tick),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .gpo_val(gpo_val), .rts_n(rts_n)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic exp);
    runs++;
    if (rts_n !== exp) begin
      fails++;
      $display("FAIL %s: rts_n=%b expected %b at %0t", req, rts_n, exp, $time);
    end
  endtask

  task automatic write_cfg(input logic ena, input logic [1:0] s);
    cfg_we = 1; cfg_wdata = {ena, s}; cyc(); cfg_we = 0;
  endtask

  task automatic char_pulse();
    char_done = 1; cyc(); char_done = 0;
  endtask

  task automatic tick();
    bit_tick = 1; cyc(); bit_tick = 0;
  endtask

  task automatic t_reset();
    gpo_val = 0; #1; check("R1", 1'b0);
    gpo_val = 1; #1; check("R1", 1'b1);
    rst_n = 1; cyc();
    check("R1", 1'b1);
  endtask

  task automatic t_disabled();
    rx_en = 1; gpo_val = 0;
    char_pulse(); check("R2", 1'b0);
    gpo_val = 1; #1; check("R2", 1'b1);
    frame_start = 1; cyc(); frame_start = 0; check("R2", 1'b1);
    gpo_val = 0; tick(); check("R2", 1'b0);
  endtask

  task automatic t_rx_off();
    rx_en = 0; write_cfg(1, 2'd0);
    check("R3", 1'b1);
    char_pulse(); check("R3", 1'b1);
    rx_en = 1; #1; check("R4", 1'b0);
    cyc(); check("R4", 1'b0);
  endtask

  task automatic t_delay(input logic [1:0] s, input int d);
    write_cfg(1, s);
    char_pulse();
    if (d == 0) check("R6", 1'b0);
    else check("R5", 1'b1);
    for (int i = 1; i <= d; i++) begin
      cyc(); check("R7", 1'b1);
      tick(); check("R5", (i < d));
    end
  endtask

  task automatic t_restart();
    write_cfg(1, 2'd2);
    char_pulse(); tick(); check("R8", 1'b1);
    char_pulse(); tick(); check("R8", 1'b1);
    tick(); check("R8", 1'b0);
  endtask

  task automatic t_hold();
    write_cfg(1, 2'd3);
    char_pulse(); tick();
    frame_start = 1; cyc(); frame_start = 0;
    for (int i = 0; i < 6; i++) tick();
    check("R9", 1'b1);
    char_pulse(); check("R9", 1'b1);
    for (int i = 0; i < 3; i++) tick();
    check("R9", 1'b1);
    tick(); check("R9", 1'b0);
    frame_start = 1; cyc(); frame_start = 0;
    check("R9", 1'b0);
  endtask

  task automatic t_same_cycle();
    write_cfg(1, 2'd1);
    char_done = 1; bit_tick = 1; cyc(); char_done = 0; bit_tick = 0;
    check("R11", 1'b1);
    tick(); check("R11", 1'b0);
  endtask

  task automatic t_init();
    write_cfg(1, 2'd3);
    char_pulse(); check("R10", 1'b1);
    gpo_val = 0;
    rx_init = 1; cfg_we = 1; cfg_wdata = 3'b111; cyc(); rx_init = 0; cfg_we = 0;
    check("R10", 1'b0);
    gpo_val = 1; #1; check("R10", 1'b1);
    write_cfg(1, 2'd0);
    check("R10", 1'b0);
    char_pulse(); check("R10", 1'b0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_rx_off();
    t_delay(2'd0, 0);
    t_delay(2'd1, 1);
    t_delay(2'd2, 2);
    t_delay(2'd3, 4);
    t_restart();
    t_hold();
    t_same_cycle();
    t_init();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    runs++; fails++;
    $display("FAIL watchdog: rts_n=%b expected completion", rts_n);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule